// File: doc/BRIEF.md
# SPI Byte Shifter with Packed Mode Byte

This block is the serial engine of an SPI master. A client presents one byte on `tx_byte` together with a packed configuration byte, pulses `start` while `ready` is high, and eight bits are exchanged on `mosi` and `miso` under a generated `sclk`. When the byte completes, `done` pulses once and `rx_byte` holds the received byte. Chip-select generation lies outside the block. A caller holding its own select low can chain bytes with no idle gap beyond the single completion cycle.

The configuration byte packs the clock rate code in bits [1:0], the clock phase in bit 2, the clock polarity in bit 3 and the bit order in bit 5. Bits 4, 6 and 7 have no effect. The rate code divides the system clock by 4, 16, 64 or 128. The block samples the configuration on every idle cycle and freezes it while a byte is in flight.

The control path is a two-state machine. In IDLE, `ready` is high, the configuration register follows `cfg`, and `sclk` rests at the polarity level. The machine moves from IDLE to SHIFT when `start` is seen. SHIFT produces sixteen half-period clock edges. The machine returns from SHIFT to IDLE on the sixteenth edge, and `done` is raised in the same step. Without `start` it stays in IDLE. Between edges it stays in SHIFT.

Top module: `spi_byte_shifter`

## Requirements
- R1: After reset, `ready`=1, `done`=0, `sclk`=0, `mosi`=0 and `rx_byte`=0.
- R2: `cfg[1:0]` sets the `sclk` half period while busy to 2, 8, 32 or 64 system clocks for codes 00, 01, 10 and 11. This gives divide-by 4, 16, 64 and 128.
- R3: `cfg[3]` is the polarity. While idle, `sclk` equals the polarity bit that was registered on the previous cycle.
- R4: `cfg[2]` is the phase.
  - With phase 0, `mosi` carries the first bit one clock after `start` is accepted. `miso` is sampled on each leading edge, and `mosi` advances on each trailing edge except the last.
  - With phase 1, `mosi` advances on each leading edge, and `miso` is sampled on each trailing edge.
  - `mosi` changes at no other time.
- R5: `cfg[5]`=1 sends and assembles the byte least-significant bit first. With `cfg[5]`=0 it is most-significant bit first.
- R6: Every byte produces exactly 16 `sclk` transitions, which is 8 bits.
- R7: `done` is high for exactly one cycle, on the cycle `ready` returns high. `rx_byte` holds the received byte from that cycle until the next completion.
- R8: A `start` presented in the cycle where `done` is high is accepted immediately, and `ready` falls on the next cycle.
- R9: A change of `cfg` while a byte is in flight has no effect on that byte's timing or data.
- R10: `start` while busy is ignored. The current byte still completes on its original schedule, and no second byte follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg | input | 8 | Packed configuration: rate [1:0], phase [2], polarity [3], LSB-first [5] |
| start | input | 1 | Request to shift one byte; taken when `ready` is high |
| tx_byte | input | 8 | Byte to transmit, captured with `start` |
| ready | output | 1 | High while idle and able to accept `start` |
| done | output | 1 | One-cycle pulse when a byte completes |
| rx_byte | output | 8 | Last received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its default eight-bit word and sweeps all 32 combinations of rate code, phase, polarity and bit order. This brings every divider, including the slowest at 64-cycle half periods, and both sampling edges within reach of an every-cycle comparison against a behavioural model. Pseudo-random `miso` and a `mosi`-to-`miso` loopback exercise the receive path. Directed runs cover chained bytes, a rate change in mid-byte and a stray `start` in mid-byte.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

    localparam int CFG_W     = 8;
    localparam int RATE_LO   = 0;
    localparam int PHASE_BIT = 2;
    localparam int POL_BIT   = 3;
    localparam int ORDER_BIT = 5;
    localparam int MAX_HALF  = 64;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } shift_state_e;

    typedef struct packed {
        logic       lsb_first;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } mode_t;

    // half period of sclk, in system clocks, for each rate code
    function automatic int unsigned half_period(input logic [1:0] code);
        int unsigned h;
        case (code)
            2'b00:   h = 2;
            2'b01:   h = 8;
            2'b10:   h = 32;
            default: h = MAX_HALF;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half_m1,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // every half period lasts at least two system clocks
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] tx_byte,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              tick,
    input  logic              lead,
    input  logic              last,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_byte
);

    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;
    logic [WORD_W-1:0] rx_next;
    logic              shift_ev;
    logic              sample_ev;

    function automatic logic front(input logic [WORD_W-1:0] v, input logic lsb);
        return lsb ? v[0] : v[WORD_W-1];
    endfunction

    function automatic logic [WORD_W-1:0] advance(input logic [WORD_W-1:0] v, input logic lsb);
        return lsb ? (v >> 1) : (v << 1);
    endfunction

    function automatic logic [WORD_W-1:0] insert(input logic [WORD_W-1:0] v, input logic b,
                                                 input logic lsb);
        return lsb ? {b, v[WORD_W-1:1]} : {v[WORD_W-2:0], b};
    endfunction

    assign shift_ev  = tick && (cpha ? lead : (!lead && !last));
    assign sample_ev = tick && (cpha ? !lead : lead);
    assign rx_next   = sample_ev ? insert(rx_q, miso, lsb_first) : rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q    <= '0;
            rx_q    <= '0;
            rx_byte <= '0;
            mosi    <= 1'b0;
        end else if (load) begin
            rx_q <= '0;
            if (!cpha) begin
                mosi <= front(tx_byte, lsb_first);
                tx_q <= advance(tx_byte, lsb_first);
            end else begin
                tx_q <= tx_byte;
            end
        end else begin
            if (shift_ev) begin
                mosi <= front(tx_q, lsb_first);
                tx_q <= advance(tx_q, lsb_first);
            end
            rx_q <= rx_next;
            if (tick && last) begin
                rx_byte <= rx_next;
            end
        end
    end

    // mosi moves only at a byte load or at a shift edge
    assert_mosi_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> $past(load || shift_ev));

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
    import spi_shift_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_byte,
    output logic              ready,
    output logic              done,
    output logic [WORD_W-1:0] rx_byte,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);

    localparam int EDGES  = 2 * WORD_W;
    localparam int EDGE_W = $clog2(EDGES);
    localparam int CNT_W  = $clog2(MAX_HALF);

    shift_state_e      state_q, state_d;
    mode_t             mode_q, mode_in, mode_eff;
    logic [EDGE_W-1:0] edge_q;
    logic              tog_q;
    logic              done_q;
    logic              tick;
    logic              lead;
    logic              last;
    logic              load;
    logic [CNT_W-1:0]  half_m1;
    logic              unused_cfg_bits;

    assign mode_in.rate      = cfg[RATE_LO+1:RATE_LO];
    assign mode_in.cpha      = cfg[PHASE_BIT];
    assign mode_in.cpol      = cfg[POL_BIT];
    assign mode_in.lsb_first = cfg[ORDER_BIT];
    assign unused_cfg_bits   = ^{cfg[7:6], cfg[4]};

    // while idle the datapath follows the live input so a load sees it
    assign mode_eff = (state_q == ST_IDLE) ? mode_in : mode_q;
    assign half_m1  = CNT_W'(half_period(mode_q.rate) - 1);
    assign lead     = ~edge_q[0];
    assign last     = (edge_q == EDGE_W'(EDGES - 1));
    assign load     = (state_q == ST_IDLE) && start;

    assign ready = (state_q == ST_IDLE);
    assign done  = done_q;
    assign sclk  = mode_q.cpol ^ tog_q;

    spi_tick_gen #(.CNT_W(CNT_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_SHIFT),
        .half_m1 (half_m1),
        .tick    (tick)
    );

    spi_shift_path #(.WORD_W(WORD_W)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .tx_byte   (tx_byte),
        .cpha      (mode_eff.cpha),
        .lsb_first (mode_eff.lsb_first),
        .tick      (tick),
        .lead      (lead),
        .last      (last),
        .miso      (miso),
        .mosi      (mosi),
        .rx_byte   (rx_byte)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)         state_d = ST_SHIFT;
            ST_SHIFT: if (tick && last)  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            edge_q <= '0;
            tog_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    mode_q <= mode_in;
                    edge_q <= '0;
                    tog_q  <= 1'b0;
                end
                ST_SHIFT: begin
                    if (tick) begin
                        tog_q  <= ~tog_q;
                        edge_q <= edge_q + EDGE_W'(1);
                        if (last) done_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    assert_done_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ready);

    assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (sclk == mode_q.cpol));

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SHIFT) && $past(state_q == ST_SHIFT)) |-> $stable(mode_q));

    assert_edge_total_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && tick && last) |=> (done_q && ready));

endmodule

// File: tb/spi_byte_shifter_test.sv
`timescale 1ns/1ps
module spi_byte_shifter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg = 8'h00;
    logic       start = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       ready, done, sclk, mosi;
    logic [7:0] rx_byte;
    logic       miso = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int miso_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    spi_byte_shifter uut (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .start(start), .tx_byte(tx_byte),
        .ready(ready), .done(done), .rx_byte(rx_byte), .sclk(sclk), .mosi(mosi),
        .miso(miso)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit       m_busy, m_done, m_mosi;
    logic [7:0] m_cfg, m_tx, m_rx, m_rxout;
    int       m_n, m_half;

    function automatic int half_of(input logic [1:0] code);
        case (code)
            2'b00: return 2;
            2'b01: return 8;
            2'b10: return 32;
            default: return 64;
        endcase
    endfunction

    function automatic bit bit_at(input logic [7:0] v, input int j, input bit lsb);
        return lsb ? v[j] : v[7-j];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_mosi = 0; m_cfg = 0; m_rxout = 0; m_n = 0; m_half = 2;
        end else begin
            m_done = 0;
            if (!m_busy) begin
                m_cfg = cfg;
                if (start) begin
                    m_busy = 1; m_n = 0; m_tx = tx_byte; m_rx = 0;
                    m_half = half_of(cfg[1:0]);
                    if (!cfg[2]) m_mosi = bit_at(tx_byte, 0, cfg[5]);
                end
            end else begin
                m_n++;
                if (m_n % m_half == 0) begin
                    int k;
                    bit lead, ph, lsb;
                    k = m_n / m_half;
                    lead = (k % 2 == 1);
                    ph = m_cfg[2];
                    lsb = m_cfg[5];
                    if (ph ? !lead : lead) begin
                        int j;
                        j = ph ? (k / 2 - 1) : ((k - 1) / 2);
                        m_rx[lsb ? j : 7 - j] = miso;
                    end
                    if (ph ? lead : (!lead && k < 16)) begin
                        int j;
                        j = ph ? ((k - 1) / 2) : (k / 2);
                        m_mosi = bit_at(m_tx, j, lsb);
                    end
                    if (k == 16) begin
                        m_busy = 0; m_done = 1; m_rxout = m_rx;
                    end
                end
            end
        end
    end

    // every-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_sclk;
            exp_sclk = m_busy ? (m_cfg[3] ^ ((m_n / m_half) % 2 == 1)) : m_cfg[3];
            if (m_busy) chk(sclk == exp_sclk, "R2 sclk rate", sclk, exp_sclk);
            else        chk(sclk == exp_sclk, "R3 sclk idle", sclk, exp_sclk);
            chk(mosi == m_mosi, "R4 mosi", mosi, m_mosi);
            chk(ready == !m_busy, "R7 ready", ready, !m_busy);
            chk(done == m_done, "R7 done", done, m_done);
            chk(rx_byte == m_rxout, "R5 rx_byte", rx_byte, m_rxout);
        end
    end

    // miso stimulus: pseudo-random or loopback
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso <= (miso_mode == 1) ? mosi : lfsr[0];
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic xfer(input logic [7:0] c, input logic [7:0] d, output int toggles, output int dur);
        logic prev;
        cfg = c;
        @(negedge clk);
        tx_byte = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        toggles = 0; dur = 0; prev = sclk;
        while (!done) begin
            @(negedge clk);
            dur++;
            if (sclk != prev) toggles++;
            prev = sclk;
        end
    endtask

    initial begin
        int tg, du;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(ready == 1'b1, "R1 ready", ready, 1);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(sclk == 1'b0, "R1 sclk", sclk, 0);
        chk(mosi == 1'b0, "R1 mosi", mosi, 0);
        chk(rx_byte == 8'h00, "R1 rx_byte", rx_byte, 0);
        @(negedge clk);

        // sweep of rate, phase, polarity and order; R6 edge count
        for (int c = 0; c < 32; c++) begin
            logic [7:0] cb;
            cb = {2'b00, c[4], 1'b0, c[3], c[2], c[1:0]};
            xfer(cb, 8'hA5 ^ 8'(c * 37), tg, du);
            chk(tg == 16, "R6 sclk transitions", tg, 16);
            chk(du == 16 * half_of(cb[1:0]), "R2 byte duration", du, 16 * half_of(cb[1:0]));
            @(negedge clk);
            chk(done == 1'b0, "R7 done single", done, 0);
        end

        // R3 polarity at rest
        cfg = 8'h08;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1, "R3 idle high", sclk, 1);
        cfg = 8'h00;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b0, "R3 idle low", sclk, 0);

        // R5 first bit on the wire for each order
        for (int l = 0; l < 2; l++) begin
            cfg = l ? 8'h20 : 8'h00;
            @(negedge clk);
            tx_byte = 8'h01; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(mosi == (l == 1), "R5 first bit", mosi, (l == 1));
            while (!done) @(negedge clk);
            @(negedge clk);
        end

        // R4 loopback: received byte equals sent byte in every mode
        miso_mode = 1;
        for (int p = 0; p < 8; p++) begin
            logic [7:0] cb, d;
            cb = {2'b00, p[2], 1'b0, p[1], p[0], 2'b00};
            d = 8'h3C ^ 8'(p * 29);
            xfer(cb, d, tg, du);
            chk(rx_byte == d, "R4 loopback", rx_byte, d);
            @(negedge clk);
        end
        miso_mode = 0;

        // R8 chained bytes
        xfer(8'h01, 8'h5A, tg, du);
        tx_byte = 8'hC3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(ready == 1'b0, "R8 back-to-back accept", ready, 0);
        while (!done) @(negedge clk);
        @(negedge clk);

        // R9 rate change in mid-byte has no effect
        cfg = 8'h00;
        @(negedge clk);
        tx_byte = 8'h96; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        du = 0;
        repeat (3) begin @(negedge clk); du++; end
        cfg = 8'h0F;
        while (!done) begin @(negedge clk); du++; end
        chk(du == 32, "R9 duration kept", du, 32);
        cfg = 8'h00;
        repeat (2) @(negedge clk);

        // R10 stray start in mid-byte
        cfg = 8'h01;
        @(negedge clk);
        tx_byte = 8'h71; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        du = 0;
        repeat (10) begin @(negedge clk); du++; end
        tx_byte = 8'hFF; start = 1'b1;
        @(negedge clk); du++;
        start = 1'b0;
        chk(ready == 1'b0, "R10 still busy", ready, 0);
        while (!done) begin @(negedge clk); du++; end
        chk(du == 128, "R10 duration kept", du, 128);
        @(negedge clk);
        chk(ready == 1'b1, "R10 no second byte", ready, 1);
        repeat (4) @(negedge clk);
        chk(ready == 1'b1, "R10 stays idle", ready, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule